// File: doc/BRIEF.md
# Receive Frame Fetch Sequencer

This block drains received frames, one at a time, from a circular receive buffer held in an external network controller's memory. It does not touch the serial bus itself. Instead it issues single-byte commands to a register engine: read a control register, write a control register, read one byte from buffer memory, or set bits in a control register. Each command is held until the engine signals completion.

The sequencer polls the controller's pending-frame count. When the count is nonzero, it points the buffer read pointer at the saved start of the next frame. It then reads a six-byte header that gives the following frame's start, the frame byte count and a receive status word. Each of these fields is 16 bits wide and arrives low byte first. Payload bytes are passed out on a valid/ready byte stream, capped at a caller-supplied maximum. The sequencer then moves the controller's free pointer to the next frame, which releases the whole frame even if it was truncated, and sets the decrement bit so that the pending count drops by one. A one-cycle completion pulse reports the delivered length and the status word.

Top module: `rxf_fetch_seq`

## Requirements
- R1: While a count poll (cmd_op 0 to the count register) returns zero, no buffer read (cmd_op 2) is issued, no stream byte is offered, and the next command is another count poll.
- R2: After a nonzero poll, the buffer read pointer is written (cmd_op 1) at the low address and then at the high address with the saved frame start. After reset the saved start equals the BUF_START parameter.
- R3: Exactly six buffer reads form the header: next-start low/high, byte count low/high, status low/high. The status is reported on frame_status.
- R4: The number of payload bytes delivered equals the smaller of the header byte count and max_len, where max_len is sampled once the header is complete. This number is reported on frame_len. No buffer read occurs past it.
- R5: Payload bytes leave in buffer order. m_tlast is set on the final delivered byte. While a byte waits on m_tready, its data and last flag hold and no further buffer read is issued.
- R6: After the payload, the release pointer is written with the header's next-start, low byte then high byte. This happens even when the payload was truncated.
- R7: After the release writes, a bit-set command (cmd_op 3) to the second control register with DEC_MASK lowers the pending count by one.
- R8: frame_done is a single-cycle pulse following the decrement command, and the next frame starts from the header's next-start.
- R9: A frame that delivers zero bytes issues no payload reads and offers no stream byte, yet still goes through the release and decrement steps.
- R10: While cmd_valid is high and cmd_done is low, cmd_op, cmd_addr and cmd_wdata stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| max_len | input | 16 | Caller's payload byte limit |
| cmd_valid | output | 1 | Command request to the register engine |
| cmd_op | output | 2 | 0 read reg, 1 write reg, 2 read buffer byte, 3 set bits |
| cmd_addr | output | 8 | Register address |
| cmd_wdata | output | 8 | Write data or bit mask |
| cmd_done | input | 1 | One-cycle completion of the held command |
| cmd_rdata | input | 8 | Read result, valid with cmd_done |
| m_tvalid | output | 1 | Payload byte valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | 8 | Payload byte |
| m_tlast | output | 1 | Final delivered byte |
| frame_done | output | 1 | Frame finished pulse |
| frame_len | output | 16 | Delivered byte count |
| frame_status | output | 16 | Receive status word |

## Verification
The bench overrides BUF_START to 0x0040, so the first pointer load can be told apart from a zero reset value. Its emulated buffer runs from 0x0040 to 0x00FF, which makes a frame straddle the wrap point within a short run. The register addresses and the decrement mask keep their defaults. Varying max_len from frame to frame reaches full delivery, truncation, and both zero-length cases.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    OP_RD_REG  = 2'd0,
    OP_WR_REG  = 2'd1,
    OP_RD_BUF  = 2'd2,
    OP_BIT_SET = 2'd3
  } rxf_op_e;

  typedef enum logic [3:0] {
    S_POLL, S_PTR_LO, S_PTR_HI, S_HDR, S_EVAL,
    S_PAY_RD, S_PAY_OUT, S_REL_LO, S_REL_HI, S_DEC
  } rxf_state_e;

  function automatic logic [15:0] rxf_min16(input logic [15:0] a, input logic [15:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [7:0] rxf_lo(input logic [15:0] v);
    return v[7:0];
  endfunction

  function automatic logic [7:0] rxf_hi(input logic [15:0] v);
    return v[15:8];
  endfunction

  function automatic logic [15:0] rxf_join(input logic [7:0] lo, input logic [7:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/rxf_hdr_capture.sv
module rxf_hdr_capture
  import rxf_pkg::*;
#(
  parameter int HDR_BYTES = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        take,
  input  logic [7:0]  byte_in,
  output logic        take_last,
  output logic [15:0] nxt_ptr,
  output logic [15:0] byte_cnt,
  output logic [15:0] rx_stat
);
  localparam int IDX_W = $clog2(HDR_BYTES);

  logic [IDX_W-1:0] idx;
  logic [7:0]       hbyte [HDR_BYTES];

  assign take_last = take && (idx == IDX_W'(HDR_BYTES-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            idx <= '0;
    else if (clr)          idx <= '0;
    else if (take && !take_last) idx <= idx + 1'b1;
  end

  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          hbyte[g] <= '0;
      else if (take && idx == IDX_W'(g))   hbyte[g] <= byte_in;
    end
  end

  assign nxt_ptr  = rxf_join(hbyte[0], hbyte[1]);
  assign byte_cnt = rxf_join(hbyte[2], hbyte[3]);
  assign rx_stat  = rxf_join(hbyte[4], hbyte[5]);

  // R3: the index never runs past the header length
  assert_hdr_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_W'(HDR_BYTES-1));

endmodule

// File: rtl/rxf_pay_tracker.sv
module rxf_pay_tracker
  import rxf_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] hdr_cnt,
  input  logic [LEN_W-1:0] cap,
  input  logic             step,
  output logic [LEN_W-1:0] total,
  output logic             remain_one
);
  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      total  <= '0;
    end else if (load) begin
      remain <= rxf_min16(hdr_cnt, cap);
      total  <= rxf_min16(hdr_cnt, cap);
    end else if (step && remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign remain_one = (remain == LEN_W'(1));

  // R4: the remaining count never exceeds what was granted
  assert_remain_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= total);

  // R4: no payload step once the grant is used up
  assert_no_overread_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> remain != '0);

endmodule

// File: rtl/rxf_byte_out.sv
module rxf_byte_out (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       lin,
  input  logic       ready,
  output logic       valid,
  output logic [7:0] data,
  output logic       last,
  output logic       accept
);
  assign accept = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      last  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= din;
      last  <= lin;
    end else if (accept) begin
      valid <= 1'b0;
    end
  end

  // R5: a stalled byte keeps its contents
  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(data) && $stable(last));

endmodule

// File: rtl/rxf_fetch_seq.sv
module rxf_fetch_seq
  import rxf_pkg::*;
#(
  parameter logic [15:0] BUF_START = 16'h0000,
  parameter logic [7:0]  CNT_REG   = 8'h19,
  parameter logic [7:0]  RDP_LO    = 8'h00,
  parameter logic [7:0]  RDP_HI    = 8'h01,
  parameter logic [7:0]  RXR_LO    = 8'h0C,
  parameter logic [7:0]  RXR_HI    = 8'h0D,
  parameter logic [7:0]  CTL2_REG  = 8'h1E,
  parameter logic [7:0]  DEC_MASK  = 8'h40,
  parameter int          HDR_BYTES = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] max_len,
  output logic        cmd_valid,
  output logic [1:0]  cmd_op,
  output logic [7:0]  cmd_addr,
  output logic [7:0]  cmd_wdata,
  input  logic        cmd_done,
  input  logic [7:0]  cmd_rdata,
  output logic        m_tvalid,
  input  logic        m_tready,
  output logic [7:0]  m_tdata,
  output logic        m_tlast,
  output logic        frame_done,
  output logic [15:0] frame_len,
  output logic [15:0] frame_status
);
  localparam int LEN_W = 16;

  rxf_state_e state, state_n;
  rxf_op_e    op_c;
  logic [15:0] saved_ptr;
  logic [15:0] nxt_ptr, byte_cnt, rx_stat, total;
  logic        remain_one, hdr_last, accept;

  // named internal events
  logic cnt_zero_ev, ptr_lo_ev, hdr_clr, hdr_take, eval_ev, pay_take, rel_hi_ev, dec_ev;
  logic [15:0] grant_now;

  assign cnt_zero_ev = (state == S_POLL)   && cmd_done && (cmd_rdata == 8'd0);
  assign ptr_lo_ev   = (state == S_PTR_LO) && cmd_done;
  assign hdr_clr     = (state == S_PTR_HI) && cmd_done;
  assign hdr_take    = (state == S_HDR)    && cmd_done;
  assign eval_ev     = (state == S_EVAL);
  assign pay_take    = (state == S_PAY_RD) && cmd_done;
  assign rel_hi_ev   = (state == S_REL_HI) && cmd_done;
  assign dec_ev      = (state == S_DEC)    && cmd_done;
  assign grant_now   = rxf_min16(byte_cnt, max_len);

  rxf_hdr_capture #(.HDR_BYTES(HDR_BYTES)) u_hdr (
    .clk(clk), .rst_n(rst_n), .clr(hdr_clr), .take(hdr_take), .byte_in(cmd_rdata),
    .take_last(hdr_last), .nxt_ptr(nxt_ptr), .byte_cnt(byte_cnt), .rx_stat(rx_stat)
  );

  rxf_pay_tracker #(.LEN_W(LEN_W)) u_pay (
    .clk(clk), .rst_n(rst_n), .load(eval_ev), .hdr_cnt(byte_cnt), .cap(max_len),
    .step(pay_take), .total(total), .remain_one(remain_one)
  );

  rxf_byte_out u_out (
    .clk(clk), .rst_n(rst_n), .load(pay_take), .din(cmd_rdata), .lin(remain_one),
    .ready(m_tready), .valid(m_tvalid), .data(m_tdata), .last(m_tlast), .accept(accept)
  );

  // command presented for the current state
  always_comb begin
    cmd_valid = 1'b1;
    op_c      = OP_RD_BUF;
    cmd_addr  = 8'h00;
    cmd_wdata = 8'h00;
    unique case (state)
      S_POLL:   begin op_c = OP_RD_REG;  cmd_addr = CNT_REG; end
      S_PTR_LO: begin op_c = OP_WR_REG;  cmd_addr = RDP_LO;  cmd_wdata = rxf_lo(saved_ptr); end
      S_PTR_HI: begin op_c = OP_WR_REG;  cmd_addr = RDP_HI;  cmd_wdata = rxf_hi(saved_ptr); end
      S_HDR, S_PAY_RD: op_c = OP_RD_BUF;
      S_REL_LO: begin op_c = OP_WR_REG;  cmd_addr = RXR_LO;  cmd_wdata = rxf_lo(nxt_ptr); end
      S_REL_HI: begin op_c = OP_WR_REG;  cmd_addr = RXR_HI;  cmd_wdata = rxf_hi(nxt_ptr); end
      S_DEC:    begin op_c = OP_BIT_SET; cmd_addr = CTL2_REG; cmd_wdata = DEC_MASK; end
      default:  cmd_valid = 1'b0;
    endcase
  end
  assign cmd_op = op_c;

  always_comb begin
    state_n = state;
    unique case (state)
      S_POLL:    if (cmd_done && cmd_rdata != 8'd0) state_n = S_PTR_LO;
      S_PTR_LO:  if (cmd_done) state_n = S_PTR_HI;
      S_PTR_HI:  if (cmd_done) state_n = S_HDR;
      S_HDR:     if (hdr_last) state_n = S_EVAL;
      S_EVAL:    state_n = (grant_now == 16'd0) ? S_REL_LO : S_PAY_RD;
      S_PAY_RD:  if (cmd_done) state_n = S_PAY_OUT;
      S_PAY_OUT: if (accept) state_n = m_tlast ? S_REL_LO : S_PAY_RD;
      S_REL_LO:  if (cmd_done) state_n = S_REL_HI;
      S_REL_HI:  if (cmd_done) state_n = S_DEC;
      S_DEC:     if (cmd_done) state_n = S_POLL;
      default:   state_n = S_POLL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_POLL;
      saved_ptr    <= BUF_START;
      frame_done   <= 1'b0;
      frame_len    <= '0;
      frame_status <= '0;
    end else begin
      state      <= state_n;
      frame_done <= dec_ev;
      if (dec_ev) begin
        saved_ptr    <= nxt_ptr;
        frame_len    <= total;
        frame_status <= rx_stat;
      end
    end
  end

  // R10: a pending command holds its fields
  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_wdata));

  // R1: an empty count leads straight to another poll
  assert_zero_repoll_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_zero_ev |=> cmd_valid && cmd_op == OP_RD_REG && cmd_addr == CNT_REG);

  // R2: low pointer byte is followed by the high byte
  assert_ptr_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_lo_ev |=> cmd_valid && cmd_op == OP_WR_REG && cmd_addr == RDP_HI);

  // R5: no buffer read while a byte waits downstream
  assert_no_read_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> !(cmd_valid && cmd_op == OP_RD_BUF));

  // R7: release completes into the decrement command
  assert_rel_then_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_hi_ev |=> cmd_valid && cmd_op == OP_BIT_SET && cmd_addr == CTL2_REG);

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R4: reported length never exceeds the header count
  assert_len_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> frame_len <= byte_cnt);

endmodule

// File: tb/rxf_fetch_seq_tb.sv
module rxf_fetch_seq_tb;
  localparam logic [15:0] BSTART = 16'h0040;
  localparam logic [15:0] BEND   = 16'h00FF;
  localparam logic [7:0] CNT_A = 8'h19, RDPL = 8'h00, RDPH = 8'h01;
  localparam logic [7:0] RXRL = 8'h0C, RXRH = 8'h0D, CTL2 = 8'h1E, DMASK = 8'h40;

  logic clk = 0, rst_n = 0;
  logic [15:0] max_len = 16'd64;
  logic cmd_valid, cmd_done = 0;
  logic [1:0] cmd_op;
  logic [7:0] cmd_addr, cmd_wdata, cmd_rdata = 0;
  logic m_tvalid, m_tready = 0, m_tlast, frame_done;
  logic [7:0] m_tdata;
  logic [15:0] frame_len, frame_status;

  always #2 clk = ~clk;

  rxf_fetch_seq #(.BUF_START(BSTART)) u_dut (
    .clk(clk), .rst_n(rst_n), .max_len(max_len),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast),
    .frame_done(frame_done), .frame_len(frame_len), .frame_status(frame_status)
  );

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural peripheral model
  logic [7:0]  mem [0:255];
  logic [15:0] rdptr = 0, exp_ptr = BSTART, wp = BSTART;
  int pktcnt = 0, lat_cnt = 0, lat_need = 1, ncmd = 0;
  int polls = 0, frame_reads = 0, beats = 0, frames_seen = 0, rdy_ctr = 0;
  bit got_lo = 0, rel_lo = 0, rel_hi = 0;
  int exp_len_q[$], exp_stat_q[$], exp_next_q[$], exp_byte_q[$];

  function automatic logic [15:0] adv(input logic [15:0] p);
    return (p == BEND) ? BSTART : p + 16'd1;
  endfunction

  task automatic put_frame(input int len, input int stat, input int cap);
    logic [15:0] p, nxt;
    int give;
    p = wp;
    for (int k = 0; k < len + 6; k++) p = adv(p);
    nxt = p;
    p = wp;
    mem[p[7:0]] = nxt[7:0];        p = adv(p);
    mem[p[7:0]] = nxt[15:8];       p = adv(p);
    mem[p[7:0]] = 8'(len);         p = adv(p);
    mem[p[7:0]] = 8'(len >> 8);    p = adv(p);
    mem[p[7:0]] = 8'(stat);        p = adv(p);
    mem[p[7:0]] = 8'(stat >> 8);   p = adv(p);
    give = (len < cap) ? len : cap;
    for (int k = 0; k < len; k++) begin
      mem[p[7:0]] = 8'(k * 13 + len + 5);
      if (k < give) exp_byte_q.push_back(int'(8'(k * 13 + len + 5)));
      p = adv(p);
    end
    exp_len_q.push_back(give);
    exp_stat_q.push_back(stat);
    exp_next_q.push_back(int'(nxt));
    wp = nxt;
  endtask

  task automatic exec_cmd();
    int nx;
    nx = (exp_next_q.size() > 0) ? exp_next_q[0] : 0;
    case (cmd_op)
      2'd0: begin
        check(cmd_addr == CNT_A, "R1 poll address", cmd_addr, CNT_A);
        cmd_rdata = 8'(pktcnt);
        polls++;
      end
      2'd1: begin
        case (cmd_addr)
          RDPL: begin
            check(cmd_wdata == exp_ptr[7:0], "R2 ptr low", cmd_wdata, exp_ptr[7:0]);
            rdptr[7:0] = cmd_wdata; got_lo = 1;
          end
          RDPH: begin
            check(got_lo, "R2 low before high", got_lo, 1);
            check(cmd_wdata == exp_ptr[15:8], "R2 ptr high", cmd_wdata, exp_ptr[15:8]);
            rdptr[15:8] = cmd_wdata; got_lo = 0;
          end
          RXRL: begin
            check(cmd_wdata == 8'(nx), "R6 release low", cmd_wdata, 8'(nx));
            rel_lo = 1;
          end
          RXRH: begin
            check(rel_lo, "R6 release low first", rel_lo, 1);
            check(cmd_wdata == 8'(nx >> 8), "R6 release high", cmd_wdata, 8'(nx >> 8));
            rel_hi = 1;
          end
          default: check(0, "R2 write address", cmd_addr, 0);
        endcase
      end
      2'd2: begin
        check(pktcnt != 0, "R1 buffer read with empty count", pktcnt, 1);
        cmd_rdata = mem[rdptr[7:0]];
        rdptr = adv(rdptr);
        frame_reads++;
      end
      default: begin
        check(cmd_addr == CTL2 && cmd_wdata == DMASK, "R7 decrement command",
              {cmd_addr, cmd_wdata}, {CTL2, DMASK});
        check(rel_hi, "R6 release before decrement", rel_hi, 1);
        if (pktcnt > 0) pktcnt--;
        exp_ptr = 16'(nx);
        rel_lo = 0; rel_hi = 0;
      end
    endcase
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      // register engine
      if (cmd_done) begin
        cmd_done = 0; lat_cnt = 0;
      end else if (cmd_valid) begin
        lat_cnt++;
        if (lat_cnt >= lat_need) begin
          exec_cmd();
          cmd_done = 1;
          ncmd++;
          lat_need = 1 + (ncmd % 3);
        end
      end
      // downstream
      rdy_ctr++;
      m_tready = ((rdy_ctr % 5) != 3) && ((rdy_ctr % 7) != 0);
      if (m_tvalid && m_tready) begin
        if (exp_byte_q.size() == 0 || exp_len_q.size() == 0) begin
          check(0, "R9 unexpected stream byte", m_tdata, 0);
        end else begin
          check(m_tdata == 8'(exp_byte_q[0]), "R5 payload byte", m_tdata, exp_byte_q[0]);
          check(m_tlast == (beats + 1 == exp_len_q[0]), "R5 last flag", m_tlast,
                (beats + 1 == exp_len_q[0]));
          void'(exp_byte_q.pop_front());
          beats++;
        end
      end
      if (frame_done) begin
        if (exp_len_q.size() == 0) begin
          check(0, "R8 unexpected frame_done", 1, 0);
        end else begin
          check(frame_len == 16'(exp_len_q[0]), "R4 delivered length", frame_len, exp_len_q[0]);
          check(frame_status == 16'(exp_stat_q[0]), "R3 status word", frame_status, exp_stat_q[0]);
          check(frame_reads == 6 + exp_len_q[0], "R9 buffer reads per frame", frame_reads,
                6 + exp_len_q[0]);
          check(beats == exp_len_q[0], "R5 beats per frame", beats, exp_len_q[0]);
          void'(exp_len_q.pop_front());
          void'(exp_stat_q.pop_front());
          void'(exp_next_q.pop_front());
        end
        frame_reads = 0; beats = 0; frames_seen++;
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_batch(input int n);
    int target;
    target = frames_seen + n;
    pktcnt = n;
    while (frames_seen < target) @(negedge clk);
    repeat (10) @(negedge clk);
    check(pktcnt == 0, "R7 count decremented to zero", pktcnt, 0);
    check(exp_byte_q.size() == 0, "R5 all bytes delivered", exp_byte_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // reset state
    check(cmd_valid && cmd_op == 2'd0, "R1 poll after reset", {cmd_valid, cmd_op}, 3'b100);
    check(!m_tvalid && !frame_done, "R8 outputs idle after reset", {m_tvalid, frame_done}, 0);

    // R1: idle with empty count
    repeat (80) @(negedge clk);
    check(polls > 5, "R1 repeated polling", polls, 6);
    check(frame_reads == 0, "R1 no reads while empty", frame_reads, 0);

    // R2 R3 R4: full delivery from initial pointer
    max_len = 16'd64;
    put_frame(5, 16'hA15C, 64);
    run_batch(1);

    // R4 R6: truncated frame still releases all of it
    max_len = 16'd8;
    put_frame(20, 16'h0321, 8);
    run_batch(1);

    // R9: empty frame, then a frame capped to zero
    max_len = 16'd64;
    put_frame(0, 16'h4000, 64);
    run_batch(1);
    max_len = 16'd0;
    put_frame(3, 16'h00FE, 0);
    run_batch(1);

    // R8: two frames back to back, second wraps the buffer
    max_len = 16'd255;
    put_frame(100, 16'h1234, 255);
    put_frame(40, 16'hBEEF, 255);
    run_batch(2);

    // R1: quiet again afterwards
    frame_reads = 0;
    repeat (60) @(negedge clk);
    check(frame_reads == 0, "R1 no reads after drain", frame_reads, 0);
    check(frames_seen == 6, "R8 frame count", frames_seen, 6);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule